// File: doc/BRIEF.md
# DRAM Clock-Frequency Change Sequencer

This block sits in a memory controller and walks an attached DDR2-class DRAM through a change of its input clock frequency. The controller first parks the DRAM in precharge power-down (all banks closed, ODT off, CKE low) or in self-refresh, then pulses a start request. If the DRAM is not in one of those two states, the request is refused with a one-cycle error pulse.

On the power-down path the sequencer waits until both the row-precharge time and the ODT turn-off time have passed, plus two more clocks. It then raises a level request to the external clock source and holds it until that source reports a stable new clock. After that it drives CKE high and waits out the power-down exit time. It issues a DLL reset through the extended mode register and keeps ODT forced off for the DLL re-lock window. Only then does it pulse ready. The three timing values are cycle counts on input ports. The re-lock length is a parameter, 200 cycles by default. On the self-refresh path the clock handshake starts at once. After the handshake the block reports ready and leaves self-refresh exit to the controller.

Top module: `dram_freq_switch`

## Requirements
- R1: After reset, and one cycle after reset is applied in the middle of a sequence, freq_req, cke_high, odt_hold, ready, reject and busy are all 0 and cmd_code is 2'b00 (NOP).
- R2: A start_req sampled while idle is accepted only when banks_precharged, odt_is_off and cke_is_low are all 1, or when in_self_refresh is 1. Otherwise reject is high for exactly the next cycle, and busy, odt_hold and freq_req stay 0.
- R3: On the power-down path, freq_req first reads 1 exactly max(t_rp, t_aofd) + 2 clock edges after the edge that accepted start_req.
- R4: freq_req stays 1 as long as clk_stable is sampled 0, and cke_high stays 0 until clk_stable has been sampled 1.
- R5: On the power-down path, cke_high reads 1 from the edge that samples clk_stable high, and freq_req drops at that same edge. cke_high stays 1 until the re-lock window ends.
- R6: cmd_code reads 2'b01 (DLL reset via the extended mode register) for exactly one cycle. That cycle comes max(t_xp, 1) edges after cke_high first reads 1.
- R7: odt_hold and busy read 1 from the accepting edge until ready has been shown, and are 0 in the cycle after ready.
- R8: After the DLL reset cycle, cmd_code stays 2'b00 with cke_high and odt_hold at 1 for RELOCK_CYCLES cycles. ready is a one-cycle pulse that reads 1 exactly RELOCK_CYCLES + 1 edges after the DLL reset cycle.
- R9: When in_self_refresh is 1 at acceptance, freq_req reads 1 right after the accepting edge, with no settle wait. ready reads 1 right after the edge that samples clk_stable high, and cke_high and a DLL reset never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to begin a frequency change |
| banks_precharged | input | 1 | All banks are closed |
| odt_is_off | input | 1 | ODT is fully turned off |
| cke_is_low | input | 1 | CKE is currently held low |
| in_self_refresh | input | 1 | DRAM is in self-refresh |
| t_rp | input | TW | Row-precharge time in cycles |
| t_aofd | input | TW | ODT turn-off delay in cycles |
| t_xp | input | TW | Power-down exit time in cycles (0 acts as 1) |
| clk_stable | input | 1 | Clock source reports the new frequency stable |
| freq_req | output | 1 | Level request to switch the clock |
| cke_high | output | 1 | Drive CKE high |
| odt_hold | output | 1 | Force ODT off |
| cmd_code | output | 2 | 00 NOP, 01 DLL reset via extended mode register |
| ready | output | 1 | One-cycle pulse: new frequency usable |
| reject | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Sequence in progress |

## Verification
A wrong wait count shows up as freq_req, the DLL reset command or ready arriving a cycle early or late. The bench measures each of these against a count it works out itself, so an off-by-one is caught at the first transition it affects. A state that skips a step shows within one cycle, for example CKE rising before the clock handshake, a DLL reset on the self-refresh path, or ODT released while CKE is high. A wrong entry decision shows at once as a missing or spurious reject pulse.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CLKSW,
        ST_XPWAIT,
        ST_DLLRST,
        ST_RELOCK,
        ST_DONE
    } fsw_state_e;

    typedef enum logic [1:0] {
        CMD_NOP       = 2'b00,
        CMD_DLL_RESET = 2'b01
    } fsw_cmd_e;

    typedef struct packed {
        logic pd_ok;
        logic sr_ok;
    } fsw_entry_t;

    localparam int unsigned SETTLE_EXTRA = 2;

    function automatic logic entry_allowed(input fsw_entry_t e);
        return e.pd_ok | e.sr_ok;
    endfunction

endpackage

// File: rtl/fsw_entry_check.sv
module fsw_entry_check
    import fsw_pkg::*;
(
    input  logic       banks_precharged,
    input  logic       odt_is_off,
    input  logic       cke_is_low,
    input  logic       in_self_refresh,
    output fsw_entry_t entry
);
    always_comb begin
        entry.pd_ok = banks_precharged & odt_is_off & cke_is_low;
        entry.sr_ok = in_self_refresh;
    end
endmodule

// File: rtl/fsw_downcount.sv
module fsw_downcount #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dram_freq_switch.sv
module dram_freq_switch
    import fsw_pkg::*;
#(
    parameter int TW            = 8,
    parameter int RELOCK_CYCLES = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          banks_precharged,
    input  logic          odt_is_off,
    input  logic          cke_is_low,
    input  logic          in_self_refresh,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_aofd,
    input  logic [TW-1:0] t_xp,
    input  logic          clk_stable,
    output logic          freq_req,
    output logic          cke_high,
    output logic          odt_hold,
    output logic [1:0]    cmd_code,
    output logic          ready,
    output logic          reject,
    output logic          busy
);
    localparam int RW = $clog2(RELOCK_CYCLES + 1);
    localparam int CW = (RW > TW + 1) ? RW : TW + 1;

    fsw_state_e    state, nxt;
    fsw_entry_t    entry;
    logic          sr_mode;
    logic          reject_q, reject_n;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          zero;

    logic [TW-1:0] longer;
    logic [CW-1:0] settle_len, xp_len, relock_len;

    fsw_entry_check u_entry (
        .banks_precharged (banks_precharged),
        .odt_is_off       (odt_is_off),
        .cke_is_low       (cke_is_low),
        .in_self_refresh  (in_self_refresh),
        .entry            (entry)
    );

    fsw_downcount #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .zero     (zero)
    );

    always_comb begin
        longer     = (t_rp > t_aofd) ? t_rp : t_aofd;
        settle_len = CW'(longer) + CW'(SETTLE_EXTRA - 1);
        xp_len     = (t_xp == '0) ? '0 : CW'(t_xp) - 1'b1;
        relock_len = CW'(RELOCK_CYCLES - 1);
    end

    always_comb begin
        nxt      = state;
        ld       = 1'b0;
        ld_val   = '0;
        reject_n = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start_req) begin
                    if (!entry_allowed(entry)) begin
                        reject_n = 1'b1;
                    end else if (entry.sr_ok) begin
                        nxt = ST_CLKSW;
                    end else begin
                        nxt    = ST_SETTLE;
                        ld     = 1'b1;
                        ld_val = settle_len;
                    end
                end
            end
            ST_SETTLE: if (zero) nxt = ST_CLKSW;
            ST_CLKSW: begin
                if (clk_stable) begin
                    if (sr_mode) begin
                        nxt = ST_DONE;
                    end else begin
                        nxt    = ST_XPWAIT;
                        ld     = 1'b1;
                        ld_val = xp_len;
                    end
                end
            end
            ST_XPWAIT: if (zero) nxt = ST_DLLRST;
            ST_DLLRST: begin
                nxt    = ST_RELOCK;
                ld     = 1'b1;
                ld_val = relock_len;
            end
            ST_RELOCK: if (zero) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sr_mode  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            state    <= nxt;
            reject_q <= reject_n;
            if (state == ST_IDLE && start_req)
                sr_mode <= entry.sr_ok;
        end
    end

    assign freq_req = (state == ST_CLKSW);
    assign cke_high = (state == ST_XPWAIT) || (state == ST_DLLRST) || (state == ST_RELOCK);
    assign odt_hold = (state != ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign cmd_code = (state == ST_DLLRST) ? 2'(CMD_DLL_RESET) : 2'(CMD_NOP);
    assign ready    = (state == ST_DONE);
    assign reject   = reject_q;
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker (
    input logic       clk,
    input logic       rst,
    input logic       clk_stable,
    input logic       freq_req,
    input logic       cke_high,
    input logic       odt_hold,
    input logic [1:0] cmd_code,
    input logic       ready,
    input logic       reject
);
    assert_reject_idle_R2: assert property (@(posedge clk) disable iff (rst)
        reject |-> !odt_hold && !freq_req);

    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        freq_req && !clk_stable |=> freq_req);

    assert_cke_after_clock_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_high) |-> $past(clk_stable) && $past(freq_req));

    assert_dll_under_cke_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_code == 2'b01 |-> cke_high && odt_hold);

    assert_dll_single_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_code == 2'b01 |=> cmd_code == 2'b00);

    assert_odt_forced_R7: assert property (@(posedge clk) disable iff (rst)
        (freq_req || cke_high) |-> odt_hold);

    assert_ready_after_nop_R8: assert property (@(posedge clk) disable iff (rst)
        ready && $past(cke_high) |-> $past(cmd_code) == 2'b00);

    assert_pulses_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ready, reject, freq_req}));
endmodule

bind dram_freq_switch fsw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_stable (clk_stable),
    .freq_req   (freq_req),
    .cke_high   (cke_high),
    .odt_hold   (odt_hold),
    .cmd_code   (cmd_code),
    .ready      (ready),
    .reject     (reject)
);

// File: tb/dram_freq_switch_bench.sv
module dram_freq_switch_bench;
    localparam int TW     = 8;
    localparam int RELOCK = 200;
    localparam int LIMIT  = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_req = 1'b0;
    logic          banks_precharged = 1'b1;
    logic          odt_is_off = 1'b1;
    logic          cke_is_low = 1'b1;
    logic          in_self_refresh = 1'b0;
    logic [TW-1:0] t_rp = '0, t_aofd = '0, t_xp = '0;
    logic          clk_stable = 1'b0;
    logic          freq_req, cke_high, odt_hold, ready, reject, busy;
    logic [1:0]    cmd_code;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // {t_rp, t_aofd, t_xp}
    localparam logic [23:0] VEC [4] = '{
        {8'd3,   8'd5,  8'd2},
        {8'd7,   8'd1,  8'd0},
        {8'd0,   8'd0,  8'd1},
        {8'd255, 8'd10, 8'd4}
    };

    always #5 clk = ~clk;

    dram_freq_switch #(.TW(TW), .RELOCK_CYCLES(RELOCK)) u_dram_freq_switch (
        .clk(clk), .rst(rst), .start_req(start_req),
        .banks_precharged(banks_precharged), .odt_is_off(odt_is_off),
        .cke_is_low(cke_is_low), .in_self_refresh(in_self_refresh),
        .t_rp(t_rp), .t_aofd(t_aofd), .t_xp(t_xp), .clk_stable(clk_stable),
        .freq_req(freq_req), .cke_high(cke_high), .odt_hold(odt_hold),
        .cmd_code(cmd_code), .ready(ready), .reject(reject), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int outs_idle();
        return {freq_req, cke_high, odt_hold, ready, reject, busy, cmd_code};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_pd(input int rp, input int aofd, input int xp);
        int cnt;
        int exp_n;
        int nop_ok;
        exp_n = ((rp > aofd) ? rp : aofd) + 2;
        t_rp = TW'(rp); t_aofd = TW'(aofd); t_xp = TW'(xp);
        start_req = 1'b1;
        step();
        start_req = 1'b0;
        chk("R7 odt_hold after accept", int'(odt_hold), 1);
        cnt = 0;
        while (!freq_req && cnt < LIMIT) begin step(); cnt++; end
        chk("R3 settle edges", cnt, exp_n);
        repeat (3) begin
            step();
            chk("R4 freq_req held", int'(freq_req), 1);
            chk("R4 cke low before stable", int'(cke_high), 0);
        end
        clk_stable = 1'b1;
        step();
        clk_stable = 1'b0;
        chk("R5 cke_high after stable", int'(cke_high), 1);
        chk("R5 freq_req dropped", int'(freq_req), 0);
        cnt = 0;
        while (cmd_code != 2'b01 && cnt < LIMIT) begin step(); cnt++; end
        chk("R6 txp edges to DLL reset", cnt, (xp < 1) ? 1 : xp);
        cnt = 0;
        nop_ok = 1;
        while (!ready && cnt < LIMIT) begin
            step(); cnt++;
            if (!ready && (cmd_code != 2'b00 || !odt_hold || !cke_high)) nop_ok = 0;
        end
        chk("R8 relock edges to ready", cnt, RELOCK + 1);
        chk("R8 NOP with odt held during relock", nop_ok, 1);
        step();
        chk("R7 released after ready", int'({odt_hold, busy, ready}), 0);
    endtask

    task automatic try_reject(input logic bp, input logic oo, input logic cl, input string tag);
        banks_precharged = bp; odt_is_off = oo; cke_is_low = cl; in_self_refresh = 1'b0;
        start_req = 1'b1;
        step();
        start_req = 1'b0;
        chk({"R2 reject pulse ", tag}, int'(reject), 1);
        chk({"R2 stays idle ", tag}, int'({busy, odt_hold, freq_req}), 0);
        step();
        chk({"R2 reject one cycle ", tag}, int'(reject), 0);
        banks_precharged = 1'b1; odt_is_off = 1'b1; cke_is_low = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", outs_idle(), 0);

        // table-driven power-down sequences: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 4; i++)
            run_pd(int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));

        // R2: each missing entry condition refuses the request
        try_reject(1'b0, 1'b1, 1'b1, "banks open");
        try_reject(1'b1, 1'b0, 1'b1, "odt on");
        try_reject(1'b1, 1'b1, 1'b0, "cke high");

        // R9: self-refresh path, even with banks flagged open
        banks_precharged = 1'b0; in_self_refresh = 1'b1; t_rp = 8'd20;
        start_req = 1'b1;
        step();
        start_req = 1'b0; in_self_refresh = 1'b0; banks_precharged = 1'b1;
        chk("R9 freq_req immediate", int'(freq_req), 1);
        clk_stable = 1'b1;
        step();
        clk_stable = 1'b0;
        chk("R9 ready after stable", int'(ready), 1);
        chk("R9 no cke or DLL", int'({cke_high, cmd_code}), 0);
        step();
        chk("R9 back to idle", outs_idle(), 0);

        // R1: reset in the middle of relock
        t_rp = 8'd1; t_aofd = 8'd1; t_xp = 8'd1;
        start_req = 1'b1;
        step();
        start_req = 1'b0;
        cnt = 0;
        while (!freq_req && cnt < LIMIT) begin step(); cnt++; end
        clk_stable = 1'b1;
        step();
        clk_stable = 1'b0;
        repeat (10) step();
        rst = 1'b1;
        step();
        chk("R1 outputs after mid-sequence reset", outs_idle(), 0);
        rst = 1'b0;
        seen = 0;
        repeat (RELOCK + 5) begin step(); if (ready) seen = 1; end
        chk("R1 no stale ready after reset", seen, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule